// File: doc/BRIEF.md
# Circular Delay-Line Address Generator

This block computes the RAM addresses for a group of FIR filters whose delay lines share one sample memory. Each filter slot is given a region: a base address, a power-of-two size, a tap count and a halfband flag. A region is accepted only if it fits the memory, is aligned to its own size and is consistent with its tap count. Each region keeps a write pointer. Every new sample takes one write cycle, and its address wraps modulo the region size.

A start strobe begins one output computation for one slot. The block takes a snapshot of that slot's write pointer. It then issues one tap pair per cycle. Read port A begins at the newest sample and moves toward older ones. Read port B begins at the oldest sample in the delay line and moves toward newer ones. The two meet in the middle, so a symmetric filter can pre-add the two samples before a single multiply.

When the tap count is odd, the pass ends with a single centre tap. In halfband mode, the taps whose coefficient is zero get no cycle at all. The memory and the arithmetic sit outside the block.

Top module: `circ_tap_agen`

## Requirements
- R1: After reset, tap_valid and cfg_err are 0 and every slot is unconfigured. For an unconfigured slot, wr_en stays 0 and a start strobe produces no taps.
- R2: A region write is rejected when any of these holds: log2 size > 8, base not a multiple of the size, base + size > 384, taps = 0, taps > size, or halfband with taps mod 4 ≠ 3. The cycle after a rejected write, cfg_err is 1 and the slot keeps its old settings and pointer. An accepted write clears cfg_err and resets the slot's write pointer to 0.
- R3: When wr_stb is high for a configured slot, wr_en is 1 in the same cycle and wr_addr = base | (h mod size), where h is the number of writes since the slot was configured. h then advances by one.
- R4: Every address that is issued lies in its region and is below 384. Addresses wrap modulo the region size.
- R5: A start strobe on an idle, configured slot makes tap_valid rise in the next cycle. In normal mode, the pass presents, in consecutive cycles, pairs of ages (k, N−1−k) for k = 0, 1, … while k < N−1−k. Age a maps to address base | ((h−1−a) mod size), where h is the pointer snapshot taken at the start cycle. A is the newest end and B the oldest end.
- R6: For odd N, the pass ends with one cycle in which tap_single = 1 and A = B = age (N−1)/2. In all other tap cycles, A ≠ B and tap_single = 0.
- R7: In halfband mode, only pairs with an even k are issued, followed by the centre age (N−1)/2 as a single tap. That gives (N+1)/4 + 1 cycles in total.
- R8: While a pass runs, start strobes are ignored. Writes to the running slot are accepted but do not change the pass addresses.
- R9: tap_last is 1 on the final tap of a pass only. tap_valid is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_sel | input | 2 | Slot being configured |
| cfg_base | input | 9 | Region base address |
| cfg_log2 | input | 4 | log2 of region size |
| cfg_taps | input | 9 | Delay-line length N |
| cfg_hb | input | 1 | Halfband skipping enable |
| cfg_err | output | 1 | Last region write was rejected |
| wr_stb | input | 1 | New sample for slot wr_sel |
| wr_sel | input | 2 | Slot receiving the sample |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | 9 | RAM write address |
| start_stb | input | 1 | Begin a pass |
| start_sel | input | 2 | Slot to compute |
| tap_valid | output | 1 | Read addresses valid |
| tap_single | output | 1 | Centre tap, only A used |
| tap_last | output | 1 | Final tap of the pass |
| rd_addr_a | output | 9 | Newest-end read address |
| rd_addr_b | output | 9 | Oldest-end read address |

## Verification
The bench builds the block with its default parameters: four slots, a 384-word memory and a largest block of 256. With these values, the bench can place a full 256-word region, a 32-word region that ends exactly at the top of memory, and regions that would cross the top and must be refused. Random write bursts of up to 300 samples per slot drive the pointers through several wraps. Passes over even, odd and halfband delay lines then check every tap address against a model of ages and offsets.

// File: rtl/circ_tap_agen.sv
module circ_tap_agen #(
  parameter int NUM_FILT  = 4,
  parameter int ADDR_W    = 9,
  parameter int RAM_WORDS = 384,
  parameter int MAX_LOG2  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(NUM_FILT)-1:0] cfg_sel,
  input  logic [ADDR_W-1:0]           cfg_base,
  input  logic [3:0]                  cfg_log2,
  input  logic [MAX_LOG2:0]           cfg_taps,
  input  logic                        cfg_hb,
  output logic                        cfg_err,
  input  logic                        wr_stb,
  input  logic [$clog2(NUM_FILT)-1:0] wr_sel,
  output logic                        wr_en,
  output logic [ADDR_W-1:0]           wr_addr,
  input  logic                        start_stb,
  input  logic [$clog2(NUM_FILT)-1:0] start_sel,
  output logic                        tap_valid,
  output logic                        tap_single,
  output logic                        tap_last,
  output logic [ADDR_W-1:0]           rd_addr_a,
  output logic [ADDR_W-1:0]           rd_addr_b
);
  localparam int FW = $clog2(NUM_FILT);
  localparam int TW = MAX_LOG2 + 1;
  localparam int HW = MAX_LOG2;
  localparam int SW = ADDR_W + 2;

  logic [ADDR_W-1:0] f_base [NUM_FILT];
  logic [3:0]        f_log2 [NUM_FILT];
  logic [TW-1:0]     f_taps [NUM_FILT];
  logic [HW-1:0]     f_head [NUM_FILT];
  logic [NUM_FILT-1:0] f_hb, f_ok;

  logic              p_busy, p_hb;
  logic [TW-1:0]     p_ka, p_kb;
  logic [HW-1:0]     p_head;
  logic [ADDR_W-1:0] p_base, p_mask;

  function automatic logic [ADDR_W-1:0] mask_of(input logic [3:0] l2);
    return ADDR_W'((SW'(1) << l2) - SW'(1));
  endfunction

  logic [SW-1:0] c_size;
  logic          c_bad;
  assign c_size = SW'(1) << cfg_log2;
  assign c_bad  = (32'(cfg_log2) > MAX_LOG2)
               || ((cfg_base & mask_of(cfg_log2)) != '0)
               || ((SW'(cfg_base) + c_size) > SW'(RAM_WORDS))
               || (cfg_taps == '0)
               || (SW'(cfg_taps) > c_size)
               || (cfg_hb && (cfg_taps[1:0] != 2'b11));

  assign wr_en   = wr_stb && f_ok[wr_sel];
  assign wr_addr = f_base[wr_sel] | (ADDR_W'(f_head[wr_sel]) & mask_of(f_log2[wr_sel]));

  logic start_go;
  assign start_go = start_stb && !p_busy && f_ok[start_sel];

  logic [HW-1:0] off_a, off_b;
  assign off_a = p_head - HW'(1) - HW'(p_ka);
  assign off_b = p_head - HW'(1) - HW'(p_kb);

  logic [TW:0] ka_w, kb_w;
  logic        step_n, step_h;
  assign ka_w   = {1'b0, p_ka};
  assign kb_w   = {1'b0, p_kb};
  assign step_n = (ka_w + (TW+1)'(2)) <= kb_w;
  assign step_h = (ka_w + (TW+1)'(4)) <  kb_w;

  assign tap_valid  = p_busy;
  assign tap_single = p_busy && (p_ka == p_kb);
  assign tap_last   = p_busy && ((p_ka == p_kb) || (!p_hb && !step_n));
  assign rd_addr_a  = p_base | (ADDR_W'(off_a) & p_mask);
  assign rd_addr_b  = p_base | (ADDR_W'(off_b) & p_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
      f_ok    <= '0;
      f_hb    <= '0;
      for (int i = 0; i < NUM_FILT; i++) begin
        f_base[i] <= '0;
        f_log2[i] <= '0;
        f_taps[i] <= '0;
        f_head[i] <= '0;
      end
    end else begin
      if (wr_en) f_head[wr_sel] <= f_head[wr_sel] + HW'(1);
      if (cfg_we) begin
        cfg_err <= c_bad;
        if (!c_bad) begin
          f_ok[cfg_sel]   <= 1'b1;
          f_hb[cfg_sel]   <= cfg_hb;
          f_base[cfg_sel] <= cfg_base;
          f_log2[cfg_sel] <= cfg_log2;
          f_taps[cfg_sel] <= cfg_taps;
          f_head[cfg_sel] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_busy <= 1'b0;
      p_hb   <= 1'b0;
      p_ka   <= '0;
      p_kb   <= '0;
      p_head <= '0;
      p_base <= '0;
      p_mask <= '0;
    end else if (start_go) begin
      p_busy <= 1'b1;
      p_hb   <= f_hb[start_sel];
      p_ka   <= '0;
      p_kb   <= f_taps[start_sel] - TW'(1);
      p_head <= f_head[start_sel];
      p_base <= f_base[start_sel];
      p_mask <= mask_of(f_log2[start_sel]);
    end else if (p_busy) begin
      if (tap_last) begin
        p_busy <= 1'b0;
      end else if (!p_hb) begin
        p_ka <= p_ka + TW'(1);
        p_kb <= p_kb - TW'(1);
      end else if (step_h) begin
        p_ka <= p_ka + TW'(2);
        p_kb <= p_kb - TW'(2);
      end else begin
        p_ka <= TW'((ka_w + kb_w) >> 1);
        p_kb <= TW'((ka_w + kb_w) >> 1);
      end
    end
  end

  p_wr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_stb);
  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < RAM_WORDS));
  p_rd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid |-> (32'(rd_addr_a) < RAM_WORDS) && (32'(rd_addr_b) < RAM_WORDS));
  p_start_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tap_valid) |-> $past(start_stb));
  p_pair_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid |-> (tap_single == (rd_addr_a == rd_addr_b)));
  p_single_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_valid && tap_single) |-> tap_last);
  p_run_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_valid && !tap_last) |=> tap_valid);
  p_last_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_valid && tap_last) |=> !tap_valid);
endmodule

// File: tb/tb_circ_tap_agen.sv
module tb_circ_tap_agen;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_hb = 0, wr_stb = 0, start_stb = 0;
  logic [1:0] cfg_sel = 0, wr_sel = 0, start_sel = 0;
  logic [8:0] cfg_base = 0, cfg_taps = 0;
  logic [3:0] cfg_log2 = 0;
  logic cfg_err, wr_en, tap_valid, tap_single, tap_last;
  logic [8:0] wr_addr, rd_addr_a, rd_addr_b;

  circ_tap_agen dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int m_base[4], m_size[4], m_taps[4], m_head[4];
  bit m_hb[4], m_ok[4];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int addr_of(int f, int h, int age);
    return m_base[f] | ((h - 1 - age) & (m_size[f] - 1));
  endfunction

  task automatic do_cfg(int f, int base, int l2, int taps, bit hb, bit bad);
    cfg_we = 1; cfg_sel = 2'(f); cfg_base = 9'(base); cfg_log2 = 4'(l2);
    cfg_taps = 9'(taps); cfg_hb = hb;
    @(negedge clk);
    cfg_we = 0;
    chk("R2 cfg_err", int'(cfg_err), int'(bad));
    if (!bad) begin
      m_ok[f] = 1; m_base[f] = base; m_size[f] = 1 << l2;
      m_taps[f] = taps; m_hb[f] = hb; m_head[f] = 0;
    end
  endtask

  task automatic do_write(int f);
    wr_stb = 1; wr_sel = 2'(f);
    #1;
    chk("R3 wr_en", int'(wr_en), int'(m_ok[f]));
    if (m_ok[f]) chk("R3 R4 wr_addr", int'(wr_addr), m_base[f] | (m_head[f] & (m_size[f] - 1)));
    @(negedge clk);
    wr_stb = 0;
    if (m_ok[f]) m_head[f]++;
  endtask

  task automatic run_pass(int f, bit inject);
    int ea[256], eb[256], n, h, oth;
    n = 0; h = m_head[f];
    if (m_hb[f]) begin
      for (int k = 0; k < m_taps[f] - 1 - k; k += 2) begin ea[n] = k; eb[n] = m_taps[f]-1-k; n++; end
      ea[n] = (m_taps[f] - 1) / 2; eb[n] = ea[n]; n++;
    end else begin
      for (int k = 0; k < m_taps[f] - 1 - k; k++) begin ea[n] = k; eb[n] = m_taps[f]-1-k; n++; end
      if (m_taps[f] % 2 == 1) begin ea[n] = m_taps[f] / 2; eb[n] = ea[n]; n++; end
    end
    start_stb = 1; start_sel = 2'(f);
    @(negedge clk);
    start_stb = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin wr_stb = 0; start_stb = 0; end
      chk("R5 tap_valid", int'(tap_valid), 1);
      chk(m_hb[f] ? "R7 addr A" : "R5 addr A", int'(rd_addr_a), addr_of(f, h, ea[i]));
      chk(m_hb[f] ? "R7 addr B" : "R5 addr B", int'(rd_addr_b), addr_of(f, h, eb[i]));
      chk("R6 tap_single", int'(tap_single), int'(ea[i] == eb[i]));
      chk("R9 tap_last", int'(tap_last), int'(i == n - 1));
      if (inject && i == 0) begin
        oth = (f + 1) % 4;
        wr_stb = 1; wr_sel = 2'(f); start_stb = 1; start_sel = 2'(oth);
        #1;
        chk("R8 wr during pass", int'(wr_addr), m_base[f] | (m_head[f] & (m_size[f] - 1)));
        m_head[f]++;
      end
      @(negedge clk);
    end
    wr_stb = 0; start_stb = 0;
    chk("R9 R8 idle after last", int'(tap_valid), 0);
  endtask

  initial begin
    int f, nw;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin m_ok[i] = 0; m_head[i] = 0; m_hb[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 tap_valid reset", int'(tap_valid), 0);
    chk("R1 cfg_err reset", int'(cfg_err), 0);
    rst_n = 1;
    @(negedge clk);
    do_write(0);
    start_stb = 1; start_sel = 0;
    @(negedge clk);
    start_stb = 0;
    chk("R1 unconfigured start", int'(tap_valid), 0);

    do_cfg(0, 0, 8, 255, 0, 0);
    do_cfg(1, 256, 6, 64, 0, 0);
    do_cfg(2, 320, 5, 31, 1, 0);
    do_cfg(3, 352, 5, 7, 0, 0);
    do_cfg(1, 320, 7, 10, 0, 1);
    do_cfg(1, 8, 5, 10, 0, 1);
    do_cfg(1, 0, 9, 10, 0, 1);
    do_cfg(1, 256, 6, 0, 0, 1);
    do_cfg(1, 352, 5, 40, 0, 1);
    do_cfg(1, 256, 6, 8, 1, 1);
    for (int i = 0; i < 5; i++) do_write(1);
    do_cfg(1, 256, 6, 64, 0, 0);
    do_write(1);

    for (int i = 0; i < 300; i++) do_write(0);
    run_pass(0, 0);
    for (int i = 0; i < 40; i++) do_write(3);
    run_pass(3, 1);
    for (int i = 0; i < 70; i++) do_write(2);
    run_pass(2, 0);
    do_cfg(2, 320, 5, 3, 1, 0);
    do_write(2);
    run_pass(2, 0);

    for (int it = 0; it < 30; it++) begin
      f = int'($urandom_range(0, 3));
      nw = int'($urandom_range(0, 300));
      for (int j = 0; j < nw; j++) do_write(int'($urandom_range(0, 3)));
      if (it % 7 == 3) begin
        if (f == 3) do_cfg(3, 352, 5, int'($urandom_range(1, 32)), 0, 0);
        if (f == 1) do_cfg(1, 256, 6, 4 * int'($urandom_range(0, 15)) + 3, 1, 0);
      end
      run_pass(f, it[0]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule